// File: doc/BRIEF.md
# Signed Min/Max Custom Instruction Unit

This unit sits next to the integer pipeline of a 32-bit processor and executes four custom operations: the signed minimum and the signed maximum of two registers, and the signed minimum and the signed maximum of a register and a sign-extended 12-bit immediate. Each cycle the pipeline hands it a raw 32-bit instruction word, a valid strobe and the two source register values. One clock edge later the unit presents a destination register index, a 32-bit result, a write enable for the register file and a flag for malformed words in its own opcode spaces.

The register-register operations use major opcode 0x0B. The register-immediate operations use major opcode 0x2B. In both spaces funct3 picks the operation: 0 is minimum and 1 is maximum. Any other major opcode belongs to the standard decoder. The unit stays silent for those words, so both decoders can watch the same instruction stream.

Top module: `minmax_exec`

## Requirements
- R1: A valid word with bits 6:0 = 0x0B, bits 14:12 = 0 and bits 31:25 = 0 produces the signed minimum of rs1_val and rs2_val.
- R2: A valid word with bits 6:0 = 0x0B, bits 14:12 = 1 and bits 31:25 = 0 produces the signed maximum of rs1_val and rs2_val.
- R3: A valid word with bits 6:0 = 0x2B and bits 14:12 = 0 produces the signed minimum of rs1_val and bits 31:20 sign-extended from bit 31. rs2_val is not used.
- R4: A valid word with bits 6:0 = 0x2B and bits 14:12 = 1 produces the signed maximum of rs1_val and bits 31:20 sign-extended from bit 31.
- R5: Comparisons treat both operands as two's complement 32-bit values. When the operands are equal, the result is that common value.
- R6: rd_idx carries bits 11:7 of the word. wr_en is high only for a valid word decoded by R1 to R4 whose bits 11:7 are not zero.
- R7: illegal is high, and wr_en stays low, for a valid word in either custom opcode space whose bits 14:12 are neither 0 nor 1. It is also high for a valid word with opcode 0x0B whose bits 31:25 are not zero.
- R8: A valid word with any other value in bits 6:0 leaves both wr_en and illegal low.
- R9: While valid is low, wr_en and illegal are low, whatever the word holds.
- R10: Outputs are registered and reflect the inputs of the previous clock edge. A synchronous active-high reset drives rd_idx, result, wr_en and illegal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Marks insn and the operands as meaningful this cycle |
| insn | input | 32 | Raw instruction word |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value (register forms only) |
| rd_idx | output | 5 | Destination register index |
| result | output | 32 | Min or max result |
| wr_en | output | 1 | Register file write request |
| illegal | output | 1 | Malformed word in a custom opcode space |

## Verification
The bench targets operand pairs that straddle the sign boundary: 0x80000000 against 0x7FFFFFFF, and negative immediates against positive registers. An unsigned comparator picks the wrong operand on these pairs, and an immediate that is zero-extended turns -33 into 4063. Equal operands, the immediate extremes 2047 and -2048, and destination x0 are also applied. A design that compares with the wrong strictness, mis-slices the immediate, or writes x0 shows up on these cases. Words with a nonzero funct7, a funct3 outside 0 and 1, foreign opcodes and an idle strobe are applied as well, because a decoder that matches only the opcode would write a result where it should raise the flag or stay silent.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

    localparam int INSN_W = 32;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 12;

    localparam logic [6:0] OPC_REGREG = 7'h0B;
    localparam logic [6:0] OPC_REGIMM = 7'h2B;
    localparam logic [2:0] SEL_MIN    = 3'd0;
    localparam logic [2:0] SEL_MAX    = 3'd1;

    typedef enum logic [1:0] {
        CLS_FOREIGN = 2'd0,
        CLS_GOOD    = 2'd1,
        CLS_BAD     = 2'd2
    } op_class_e;

    typedef enum logic {
        CMP_NATIVE = 1'b0,
        CMP_SPLIT  = 1'b1
    } cmp_style_e;

    typedef struct packed {
        op_class_e         cls;
        logic              take_max;
        logic              use_imm;
        logic [RIDX_W-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic logic f3_known(input logic [2:0] f3);
        return (f3 == SEL_MIN) || (f3 == SEL_MAX);
    endfunction

endpackage

// File: rtl/minmax_decode.sv
module minmax_decode
    import minmax_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];
    assign f7  = insn[31:25];

    always_comb begin
        dec          = '0;
        dec.cls      = CLS_FOREIGN;
        dec.take_max = f3[0];
        dec.rd       = insn[11:7];
        dec.imm      = insn[31:20];
        dec.use_imm  = 1'b0;
        if (valid) begin
            if (opc == OPC_REGREG) begin
                dec.use_imm = 1'b0;
                dec.cls     = (f3_known(f3) && (f7 == 7'd0)) ? CLS_GOOD : CLS_BAD;
            end else if (opc == OPC_REGIMM) begin
                dec.use_imm = 1'b1;
                dec.cls     = f3_known(f3) ? CLS_GOOD : CLS_BAD;
            end
        end
    end
endmodule

// File: rtl/minmax_select.sv
module minmax_select
    import minmax_pkg::*;
#(
    parameter int         XLEN  = 32,
    parameter cmp_style_e STYLE = CMP_NATIVE
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            take_max,
    output logic [XLEN-1:0] y
);
    localparam int MSB = XLEN - 1;

    logic a_lt_b;

    generate
        if (STYLE == CMP_NATIVE) begin : g_native
            assign a_lt_b = $signed(opa) < $signed(opb);
        end else begin : g_split
            // Differing signs decide at once; otherwise the low bits compare unsigned.
            assign a_lt_b = (opa[MSB] != opb[MSB]) ? opa[MSB]
                                                   : (opa[MSB-1:0] < opb[MSB-1:0]);
        end
    endgenerate

    always_comb begin
        if (take_max) y = a_lt_b ? opb : opa;
        else          y = a_lt_b ? opa : opb;
    end
endmodule

// File: rtl/minmax_exec.sv
module minmax_exec
    import minmax_pkg::*;
#(
    parameter int         XLEN  = 32,
    parameter cmp_style_e STYLE = CMP_NATIVE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic [4:0]        rd_idx,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic              illegal
);
    localparam int EXT_W = XLEN - IMM_W;

    dec_t            dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] sel_y;
    logic            we_next;
    logic            ill_next;

    minmax_decode i_decode (
        .valid (valid),
        .insn  (insn),
        .dec   (dec)
    );

    assign imm_ext = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
    assign opb     = dec.use_imm ? imm_ext : rs2_val;

    minmax_select #(.XLEN(XLEN), .STYLE(STYLE)) i_select (
        .opa      (rs1_val),
        .opb      (opb),
        .take_max (dec.take_max),
        .y        (sel_y)
    );

    assign we_next  = (dec.cls == CLS_GOOD) && (dec.rd != '0);
    assign ill_next = (dec.cls == CLS_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            result  <= '0;
            wr_en   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            rd_idx  <= dec.rd;
            result  <= sel_y;
            wr_en   <= we_next;
            illegal <= ill_next;
        end
    end
endmodule

// File: rtl/minmax_exec_chk.sv
module minmax_exec_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            valid,
    input logic [31:0]     insn,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [4:0]      rd_idx,
    input logic [XLEN-1:0] result,
    input logic            wr_en,
    input logic            illegal
);
    logic is_custom;
    logic rr_ok;
    logic [XLEN-1:0] imm_x;

    assign is_custom = (insn[6:0] == 7'h0B) || (insn[6:0] == 7'h2B);
    assign rr_ok     = valid && insn[6:0] == 7'h0B && insn[31:25] == 7'd0 && insn[11:7] != 5'd0;
    assign imm_x     = {{(XLEN-12){insn[31]}}, insn[31:20]};

    a_r1_rr_min: assert property (@(posedge clk) disable iff (rst)
        (rr_ok && insn[14:12] == 3'd0) |=> wr_en
            && $signed(result) <= $signed($past(rs1_val))
            && $signed(result) <= $signed($past(rs2_val))
            && (result == $past(rs1_val) || result == $past(rs2_val)));

    a_r2_rr_max: assert property (@(posedge clk) disable iff (rst)
        (rr_ok && insn[14:12] == 3'd1) |=> wr_en
            && $signed(result) >= $signed($past(rs1_val))
            && $signed(result) >= $signed($past(rs2_val))
            && (result == $past(rs1_val) || result == $past(rs2_val)));

    a_r3_ri_min: assert property (@(posedge clk) disable iff (rst)
        (valid && insn[6:0] == 7'h2B && insn[14:12] == 3'd0 && insn[11:7] != 5'd0) |=>
            wr_en && $signed(result) <= $signed($past(rs1_val))
                  && $signed(result) <= $signed($past(imm_x)));

    a_r6_no_x0_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rd_idx != 5'd0);

    a_r6_rd_field: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rd_idx == $past(insn[11:7]));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && illegal));

    a_r8_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
        (valid && !is_custom) |=> !wr_en && !illegal);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |=> !wr_en && !illegal);
endmodule

bind minmax_exec minmax_exec_chk #(.XLEN(XLEN)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid),
    .insn    (insn),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .rd_idx  (rd_idx),
    .result  (result),
    .wr_en   (wr_en),
    .illegal (illegal)
);

// File: tb/test_minmax_exec.sv
`timescale 1ns/1ps
module test_minmax_exec;

    typedef struct packed {
        logic [31:0] insn;
        logic [31:0] a;
        logic [31:0] b;
        logic        we;
        logic        ill;
        logic [4:0]  rd;
        logic [31:0] res;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0057858B, 32'd42, 32'hFFFFFFF5, 1'b1, 1'b0, 5'd11, 32'hFFFFFFF5, 4'd1},  // R1
        '{32'h0103960B, 32'd84, 32'hFFFFFFEA, 1'b1, 1'b0, 5'd12, 32'd84, 4'd2},        // R2
        '{32'hFDFE06AB, 32'd126, 32'h12345678, 1'b1, 1'b0, 5'd13, 32'hFFFFFFDF, 4'd3}, // R3
        '{32'hFC93982B, 32'd210, 32'h0, 1'b1, 1'b0, 5'd16, 32'd210, 4'd4},             // R4
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd3, 7'h0B), 32'h80000000, 32'h7FFFFFFF,
          1'b1, 1'b0, 5'd3, 32'h80000000, 4'd5},                                      // R5
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd1, 5'd4, 7'h0B), 32'h80000000, 32'h7FFFFFFF,
          1'b1, 1'b0, 5'd4, 32'h7FFFFFFF, 4'd5},                                      // R5
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd1, 5'd5, 7'h0B), 32'd5, 32'd5,
          1'b1, 1'b0, 5'd5, 32'd5, 4'd5},                                             // R5
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd31, 7'h0B), 32'hFFFFFFF9, 32'hFFFFFFF9,
          1'b1, 1'b0, 5'd31, 32'hFFFFFFF9, 4'd5},                                     // R5
        '{enc_i(12'h7FF, 5'd1, 3'd0, 5'd6, 7'h2B), 32'd3000, 32'h0,
          1'b1, 1'b0, 5'd6, 32'd2047, 4'd3},                                          // R3
        '{enc_i(12'h800, 5'd1, 3'd1, 5'd7, 7'h2B), 32'hFFFFEC78, 32'h0,
          1'b1, 1'b0, 5'd7, 32'hFFFFF800, 4'd4},                                      // R4
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd0, 7'h0B), 32'd1, 32'd2,
          1'b0, 1'b0, 5'd0, 32'd1, 4'd6},                                             // R6
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd2, 5'd8, 7'h0B), 32'd1, 32'd2,
          1'b0, 1'b1, 5'd8, 32'd0, 4'd7},                                             // R7
        '{enc_r(7'h20, 5'd2, 5'd1, 3'd0, 5'd8, 7'h0B), 32'd1, 32'd2,
          1'b0, 1'b1, 5'd8, 32'd0, 4'd7},                                             // R7
        '{enc_i(12'h000, 5'd1, 3'd7, 5'd9, 7'h2B), 32'd1, 32'd2,
          1'b0, 1'b1, 5'd9, 32'd0, 4'd7},                                             // R7
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd9, 7'h33), 32'd1, 32'd2,
          1'b0, 1'b0, 5'd9, 32'd0, 4'd8},                                             // R8
        '{enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd9, 7'h5B), 32'd1, 32'd2,
          1'b0, 1'b0, 5'd9, 32'd0, 4'd8}                                              // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [4:0]  rd_idx;
    logic [31:0] result;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    minmax_exec i_minmax_exec (
        .clk     (clk),
        .rst     (rst),
        .valid   (valid),
        .insn    (insn),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .rd_idx  (rd_idx),
        .result  (result),
        .wr_en   (wr_en),
        .illegal (illegal)
    );

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        valid = v; insn = w; rs1_val = a; rs2_val = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset holds outputs at zero even with a legal word presented
        valid = 1'b1; insn = 32'h0057858B; rs1_val = 32'd42; rs2_val = 32'd7;
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0 && illegal == 1'b0, 10, "reset flags",
              {30'd0, wr_en, illegal}, 32'd0);
        check(result == 32'd0 && rd_idx == 5'd0, 10, "reset data", result, 32'd0);
        rst = 1'b0;
        valid = 1'b0;

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].insn, VECS[i].a, VECS[i].b);
            check(wr_en == VECS[i].we, VECS[i].req, $sformatf("wr_en vec %0d", i),
                  {31'd0, wr_en}, {31'd0, VECS[i].we});
            check(illegal == VECS[i].ill, VECS[i].req, $sformatf("illegal vec %0d", i),
                  {31'd0, illegal}, {31'd0, VECS[i].ill});
            if (VECS[i].we) begin
                check(rd_idx == VECS[i].rd, VECS[i].req, $sformatf("rd vec %0d", i),
                      {27'd0, rd_idx}, {27'd0, VECS[i].rd});
                check(result == VECS[i].res, VECS[i].req, $sformatf("result vec %0d", i),
                      result, VECS[i].res);
            end
        end

        // R9: idle strobe with a legal and a malformed word
        drive(1'b0, 32'h0103960B, 32'd84, 32'd1);
        check(!wr_en && !illegal, 9, "idle legal word", {30'd0, wr_en, illegal}, 32'd0);
        drive(1'b0, enc_r(7'h7F, 5'd1, 5'd1, 3'd5, 5'd1, 7'h0B), 32'd0, 32'd0);
        check(!wr_en && !illegal, 9, "idle bad word", {30'd0, wr_en, illegal}, 32'd0);

        // R10: one-edge latency; output unchanged before the edge
        @(negedge clk);
        valid = 1'b1; insn = 32'h0103960B; rs1_val = 32'd9; rs2_val = 32'd3;
        #1;
        check(wr_en == 1'b0, 10, "before edge", {31'd0, wr_en}, 32'd0);
        @(negedge clk);
        check(wr_en == 1'b1 && result == 32'd9, 10, "after edge", result, 32'd9);

        // R10: reset in mid-stream clears a pending write
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!wr_en && result == 32'd0 && rd_idx == 5'd0, 10, "mid reset", result, 32'd0);
        rst = 1'b0; valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule